// File: doc/BRIEF.md
# Identity-Bound Feature Enable Gate

This block ties a design to the silicon it runs on. After reset it reads the device's 57-bit factory identifier from a read-only serial port. It drives a load strobe and then a run of shift strobes to do this. It then combines that value with a 32-bit one-time-programmable user identifier and a secret 64-bit key into a 64-bit checksum. The keyed mixing function runs one round per clock. A reference checksum is produced off-chip with the same algorithm and key, and it arrives from external non-volatile storage with a valid strobe. The block compares its own result against that reference.

The outcome is a latched verdict. A match grants full operation, and a mismatch either refuses operation or grants only a reduced-feature enable, depending on a policy input. Until both the checksum and the reference are available, every enable stays low. Once the verdict is taken, nothing but reset can change it.

Top module: `id_gate_top`

## Requirements
- R1: After reset is released, `id_load_o` is high for exactly one cycle. It is followed by exactly 57 consecutive cycles with `id_shift_o` high, and no strobe follows until the next reset. On each clock edge with `id_shift_o` high, `id_bit_i` is sampled. The first bit sampled is factory-ID bit 56 (MSB first).
- R2: The message is M[127:0] = {user_id, 7'b0, F, 32'h9E3779B9}. F is the factory ID when `combine_i` = 1 and all zeros when `combine_i` = 0. `combine_i` and `user_id_i` are taken on the cycle the checksum starts.
- R3: The checksum is computed as follows. Start with h = key. For each round r = 0 .. ROUNDS-1 (default 16), let w be 32-bit word (r mod 4) of M, where word 0 is bits 31:0. Compute t = rotl64(h ^ {w, ~w}, ROT) + rotl64(key, r mod 64), with ROT defaulting to 13. Then set h = t ^ (t >> 7).
- R4: Only the first `ref_valid_i` pulse after reset captures `ref_sum_i`. Later pulses are ignored.
- R5: `full_en_o` and `lite_en_o` stay low while `decided_o` is low. `decided_o` rises one cycle after both the checksum is complete and a reference is captured. With an early reference, this is the 60+ROUNDS-th rising edge after reset release. In general it is edge max(60+ROUNDS, reference edge + 1).
- R6: If the checksum equals the captured reference, both `full_en_o` and `lite_en_o` are 1.
- R7: On a mismatch with `strict_i` = 1, both enables are 0 (refuse). On a mismatch with `strict_i` = 0, only `lite_en_o` is 1. `strict_i` is taken in the cycle the verdict is made.
- R8: Once `decided_o` is 1, the enables and `decided_o` hold until reset. This holds even if later reference pulses, policy changes or identifier changes arrive.
- R9: While reset is asserted, `decided_o`, `full_en_o`, `lite_en_o` and `id_shift_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_load_o | output | 1 | Load strobe to the factory-ID serial port |
| id_shift_o | output | 1 | Shift strobe to the factory-ID serial port |
| id_bit_i | input | 1 | Serial factory-ID data bit |
| user_id_i | input | 32 | One-time-programmable user identifier |
| combine_i | input | 1 | 1: include factory ID in the message |
| ref_sum_i | input | 64 | Reference checksum from external storage |
| ref_valid_i | input | 1 | Reference checksum valid strobe |
| key_i | input | 64 | Constant secret key |
| strict_i | input | 1 | Mismatch policy: 1 refuse, 0 limited |
| full_en_o | output | 1 | Full-operation enable |
| lite_en_o | output | 1 | Reduced-feature enable |
| decided_o | output | 1 | Verdict has been taken and latched |

## Verification
Two events can coincide in one cycle: the reference strobe and the final checksum round. The bench provokes this by placing the strobe on exactly the edge where the last round completes, which is edge 59+ROUNDS after release. It then requires the verdict one edge later with the correct match result, at the same edge as with an early reference. A second collision places a new reference strobe next to an already-captured one, both before and after the verdict. The bench then judges that only the first value decides the outcome and that nothing moves after the verdict.

// File: rtl/idg_pkg.sv
package idg_pkg;
  localparam int FID_W = 57;
  localparam int UID_W = 32;
  localparam int SUM_W = 64;
  localparam int WORD_W = 32;
  localparam int MSG_W = 4 * WORD_W;
  localparam int PAD_W = MSG_W - UID_W - FID_W - WORD_W;
  localparam logic [WORD_W-1:0] SEP_WORD = 32'h9E37_79B9;

  typedef logic [SUM_W-1:0] sum_t;
  typedef logic [MSG_W-1:0] msg_t;
  typedef enum logic [1:0] {RD_LOAD, RD_SHIFT, RD_DONE} rd_phase_e;

  function automatic sum_t rotl(sum_t v, int unsigned s);
    int unsigned k;
    k = s % SUM_W;
    if (k == 0) return v;
    return (v << k) | (v >> (SUM_W - k));
  endfunction

  function automatic msg_t build_msg(logic [UID_W-1:0] uid, logic [FID_W-1:0] fid, logic use_fid);
    logic [FID_W-1:0] f;
    f = use_fid ? fid : '0;
    return {uid, {PAD_W{1'b0}}, f, SEP_WORD};
  endfunction

  function automatic sum_t mix_round(sum_t h, sum_t key, logic [WORD_W-1:0] w,
                                     int unsigned r, int unsigned rot);
    sum_t t;
    t = rotl(h ^ {w, ~w}, rot) + rotl(key, r);
    return t ^ (t >> 7);
  endfunction
endpackage

// File: rtl/idg_id_reader.sv
module idg_id_reader
  import idg_pkg::*;
#(
  parameter int ID_W = FID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  output logic            load_o,
  output logic            shift_o,
  output logic [ID_W-1:0] id_o,
  output logic            done_o
);
  localparam int CW = $clog2(ID_W);

  rd_phase_e          phase;
  logic [CW-1:0]      cnt;
  logic [ID_W-1:0]    sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= RD_LOAD;
      cnt   <= '0;
      sr    <= '0;
    end else begin
      unique case (phase)
        RD_LOAD: phase <= RD_SHIFT;
        RD_SHIFT: begin
          sr  <= {sr[ID_W-2:0], bit_i};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ID_W - 1)) phase <= RD_DONE;
        end
        default: phase <= RD_DONE;
      endcase
    end
  end

  assign load_o  = (phase == RD_LOAD);
  assign shift_o = (phase == RD_SHIFT) && rst_n;
  assign id_o    = sr;
  assign done_o  = (phase == RD_DONE);
endmodule

// File: rtl/idg_mixer.sv
module idg_mixer
  import idg_pkg::*;
#(
  parameter int ROUNDS = 16,
  parameter int ROT    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [UID_W-1:0] uid_i,
  input  logic [FID_W-1:0] fid_i,
  input  logic             use_fid_i,
  input  sum_t             key_i,
  output sum_t             sum_o,
  output logic             done_o,
  output logic             start_o
);
  localparam int RW = (ROUNDS < 4) ? 2 : $clog2(ROUNDS + 1);

  logic          ran, busy;
  logic [RW-1:0] rnd;
  msg_t          msg;
  sum_t          h;
  logic [WORD_W-1:0] word;

  assign start_o = go_i && !ran;
  assign word    = msg[rnd[1:0]*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ran    <= 1'b0;
      busy   <= 1'b0;
      rnd    <= '0;
      msg    <= '0;
      h      <= '0;
      done_o <= 1'b0;
    end else if (start_o) begin
      ran  <= 1'b1;
      busy <= 1'b1;
      rnd  <= '0;
      msg  <= build_msg(uid_i, fid_i, use_fid_i);
      h    <= key_i;
    end else if (busy) begin
      h   <= mix_round(h, key_i, word, int'(rnd), ROT);
      rnd <= rnd + 1'b1;
      if (rnd == RW'(ROUNDS - 1)) begin
        busy   <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  assign sum_o = h;
endmodule

// File: rtl/idg_verdict.sv
module idg_verdict
  import idg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_valid_i,
  input  sum_t ref_sum_i,
  input  sum_t sum_i,
  input  logic sum_done_i,
  input  logic strict_i,
  output logic full_en_o,
  output logic lite_en_o,
  output logic decided_o,
  output logic ref_take_o,
  output logic ref_held_o
);
  sum_t ref_q;
  logic held, decided, match_q, strict_q, ready;

  assign ref_take_o = ref_valid_i && !held;
  assign ready      = sum_done_i && held && !decided;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      held     <= 1'b0;
      decided  <= 1'b0;
      match_q  <= 1'b0;
      strict_q <= 1'b1;
    end else begin
      if (ref_take_o) begin
        ref_q <= ref_sum_i;
        held  <= 1'b1;
      end
      if (ready) begin
        decided  <= 1'b1;
        match_q  <= (sum_i == ref_q);
        strict_q <= strict_i;
      end
    end
  end

  assign decided_o  = decided;
  assign full_en_o  = decided && match_q;
  assign lite_en_o  = decided && (match_q || !strict_q);
  assign ref_held_o = held;
endmodule

// File: rtl/id_gate_top.sv
module id_gate_top
  import idg_pkg::*;
#(
  parameter int ROUNDS = 16,
  parameter int ROT    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              id_load_o,
  output logic              id_shift_o,
  input  logic              id_bit_i,
  input  logic [UID_W-1:0]  user_id_i,
  input  logic              combine_i,
  input  logic [SUM_W-1:0]  ref_sum_i,
  input  logic              ref_valid_i,
  input  logic [SUM_W-1:0]  key_i,
  input  logic              strict_i,
  output logic              full_en_o,
  output logic              lite_en_o,
  output logic              decided_o
);
  logic [FID_W-1:0] fid_w;
  logic             fid_done_w;
  sum_t             sum_w;
  logic             sum_done_w;
  logic             mix_start_w;
  logic             ref_take_w;
  logic             ref_held_w;

  idg_id_reader #(.ID_W(FID_W)) u_reader (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_i   (id_bit_i),
    .load_o  (id_load_o),
    .shift_o (id_shift_o),
    .id_o    (fid_w),
    .done_o  (fid_done_w)
  );

  idg_mixer #(.ROUNDS(ROUNDS), .ROT(ROT)) u_mixer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (fid_done_w),
    .uid_i     (user_id_i),
    .fid_i     (fid_w),
    .use_fid_i (combine_i),
    .key_i     (key_i),
    .sum_o     (sum_w),
    .done_o    (sum_done_w),
    .start_o   (mix_start_w)
  );

  idg_verdict u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_valid_i (ref_valid_i),
    .ref_sum_i   (ref_sum_i),
    .sum_i       (sum_w),
    .sum_done_i  (sum_done_w),
    .strict_i    (strict_i),
    .full_en_o   (full_en_o),
    .lite_en_o   (lite_en_o),
    .decided_o   (decided_o),
    .ref_take_o  (ref_take_w),
    .ref_held_o  (ref_held_w)
  );
endmodule

// File: rtl/id_gate_sva.sv
module id_gate_sva #(
  parameter int ID_W = 57
) (
  input logic clk,
  input logic rst_n,
  input logic ld,
  input logic sh,
  input logic full_en,
  input logic lite_en,
  input logic decided,
  input logic sum_done,
  input logic ref_take,
  input logic ref_held
);
  int unsigned sh_seen;
  int unsigned take_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_seen   <= 0;
      take_seen <= 0;
    end else begin
      if (sh) sh_seen <= sh_seen + 1;
      if (ref_take) take_seen <= take_seen + 1;
    end
  end

  a_r1_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n) !(ld && sh));
  a_r1_single_load:   assert property (@(posedge clk) disable iff (!rst_n) ld |=> !ld);
  a_r1_shift_bound:   assert property (@(posedge clk) disable iff (!rst_n) sh_seen <= ID_W);
  a_r4_one_capture:   assert property (@(posedge clk) disable iff (!rst_n) take_seen <= 1);
  a_r5_locked:        assert property (@(posedge clk) disable iff (!rst_n)
                                       !decided |-> (!full_en && !lite_en));
  a_r5_needs_both:    assert property (@(posedge clk) disable iff (!rst_n)
                                       $rose(decided) |-> ($past(sum_done) && $past(ref_held)));
  a_r6_full_has_lite: assert property (@(posedge clk) disable iff (!rst_n) full_en |-> lite_en);
  a_r8_latched:       assert property (@(posedge clk) disable iff (!rst_n)
                                       decided |=> (decided && $stable(full_en) && $stable(lite_en)));
endmodule

bind id_gate_top id_gate_sva #(.ID_W(idg_pkg::FID_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld       (id_load_o),
  .sh       (id_shift_o),
  .full_en  (full_en_o),
  .lite_en  (lite_en_o),
  .decided  (decided_o),
  .sum_done (sum_done_w),
  .ref_take (ref_take_w),
  .ref_held (ref_held_w)
);

// File: tb/id_gate_top_tb_top.sv
module id_gate_top_tb_top;
  localparam int NR  = 16;
  localparam int RT  = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_load_o, id_shift_o, id_bit_i;
  logic [31:0] user_id_i = '0;
  logic        combine_i = 1'b0;
  logic [63:0] ref_sum_i = '0;
  logic        ref_valid_i = 1'b0;
  logic [63:0] key_i = '0;
  logic        strict_i = 1'b0;
  logic        full_en_o, lite_en_o, decided_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [56:0] fid_cur = '0;
  logic [56:0] port_reg = '0;

  always #4 clk = ~clk;

  id_gate_top #(.ROUNDS(NR), .ROT(RT)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_load_o(id_load_o), .id_shift_o(id_shift_o),
    .id_bit_i(id_bit_i), .user_id_i(user_id_i), .combine_i(combine_i),
    .ref_sum_i(ref_sum_i), .ref_valid_i(ref_valid_i), .key_i(key_i),
    .strict_i(strict_i), .full_en_o(full_en_o), .lite_en_o(lite_en_o),
    .decided_o(decided_o)
  );

  // read-only serial ID port model
  always @(posedge clk) begin
    if (id_load_o) port_reg <= fid_cur;
    else if (id_shift_o) port_reg <= {port_reg[55:0], 1'b0};
  end
  assign id_bit_i = port_reg[56];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    nfail++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  function automatic logic [63:0] rl(logic [63:0] v, int n);
    int m = n % 64;
    logic [127:0] d = {v, v};
    return d[127-m -: 64];
  endfunction

  // R2 R3 restated
  function automatic logic [63:0] model_sum(logic [31:0] uid, logic [56:0] fid, bit comb,
                                            logic [63:0] key);
    logic [31:0] wd [4];
    logic [63:0] h, t;
    logic [56:0] f = comb ? fid : 57'd0;
    wd[0] = 32'h9E37_79B9;
    wd[1] = f[31:0];
    wd[2] = {7'd0, f[56:32]};
    wd[3] = uid;
    h = key;
    for (int r = 0; r < NR; r++) begin
      t = rl(h ^ {wd[r % 4], ~wd[r % 4]}, RT) + rl(key, r);
      h = t ^ {7'd0, t[63:7]};
    end
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic trial(input logic [31:0] uid, input logic [63:0] key, input logic [56:0] fid,
                       input bit comb, input bit strict, input int e1, input bit good1,
                       input int e2, input bit good2);
    logic [63:0] cs, v1, v2;
    bit exp_match, early_on;
    int e, ld_n, sh_n, exp_edge;
    logic [2:0] snap;
    cs = model_sum(uid, fid, comb, key);
    v1 = good1 ? cs : cs ^ 64'h0000_0100_0000_0000;
    v2 = good2 ? cs : cs ^ 64'h0000_0000_0000_0080;
    exp_match = good1;
    exp_edge = (e1 + 1 > 60 + NR) ? e1 + 1 : 60 + NR;
    @(negedge clk);
    rst_n = 1'b0;
    user_id_i = uid; key_i = key; fid_cur = fid; combine_i = comb; strict_i = strict;
    ref_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({decided_o, full_en_o, lite_en_o, id_shift_o} == 4'b0, "R9 reset state",
        {decided_o, full_en_o, lite_en_o, id_shift_o}, 0);
    rst_n = 1'b1;
    e = 0; ld_n = 0; sh_n = 0; early_on = 0;
    while (!decided_o && e < 1000) begin
      e++;
      ref_valid_i = (e == e1) || (e == e2);
      ref_sum_i   = (e == e1) ? v1 : v2;
      if (id_load_o) ld_n++;
      if (id_shift_o) sh_n++;
      @(posedge clk);
      @(negedge clk);
      ref_valid_i = 1'b0;
      if (!decided_o && (full_en_o || lite_en_o)) early_on = 1;
    end
    chk(!early_on, "R5 enables low before verdict", 64'(early_on), 0);
    chk(e == exp_edge, "R5 verdict edge", 64'(e), 64'(exp_edge));
    chk(ld_n == 1 && sh_n == 57, "R1 strobe counts (ld,sh)", {32'(ld_n), 32'(sh_n)}, {32'd1, 32'd57});
    chk(full_en_o == exp_match, exp_match ? "R6 full enable on match" : "R7 full off on mismatch",
        64'(full_en_o), 64'(exp_match));
    chk(lite_en_o == (exp_match || !strict), exp_match ? "R6 lite on match" : "R7 mismatch policy",
        64'(lite_en_o), 64'(exp_match || !strict));
    if (e2 > 0 && e2 < e) chk(full_en_o == exp_match, "R4 later strobe ignored",
                              64'(full_en_o), 64'(exp_match));
    // R8: disturb everything after the verdict
    snap = {decided_o, full_en_o, lite_en_o};
    for (int k = 0; k < 10; k++) begin
      ref_valid_i = k[0];
      ref_sum_i   = exp_match ? ~cs : cs;
      strict_i    = ~strict_i;
      user_id_i   = user_id_i ^ 32'hFFFF_0000;
      combine_i   = ~combine_i;
      if (id_load_o) ld_n++;
      if (id_shift_o) sh_n++;
      @(posedge clk);
      @(negedge clk);
      ref_valid_i = 1'b0;
      if ({decided_o, full_en_o, lite_en_o} != snap)
        chk(0, "R8 verdict moved", 64'({decided_o, full_en_o, lite_en_o}), 64'(snap));
    end
    chk({decided_o, full_en_o, lite_en_o} == snap, "R8 verdict held",
        64'({decided_o, full_en_o, lite_en_o}), 64'(snap));
    chk(ld_n == 1 && sh_n == 57, "R1 no strobes after read", {32'(ld_n), 32'(sh_n)}, {32'd1, 32'd57});
  endtask

  initial begin
    void'($urandom(32'd4711));
    // directed corners
    trial(32'hDEAD_BEEF, 64'h0123_4567_89AB_CDEF, 57'h1AB_CDEF_0123_4567, 1, 1, 5, 1, 0, 0);
    trial(32'h1234_5678, 64'hFEDC_BA98_7654_3210, 57'h100_0000_0000_0000, 1, 1, 30, 0, 0, 0);
    trial(32'h0000_0001, 64'hA5A5_5A5A_0F0F_F0F0, 57'h000_0000_0000_0001, 1, 0, 5, 0, 0, 0);
    trial(32'hCAFE_F00D, 64'h1111_2222_3333_4444, 57'h0FF_FFFF_FFFF_FFFF, 0, 1, 5, 1, 0, 0);   // R2 combine off
    trial(32'h8000_0000, 64'h0F1E_2D3C_4B5A_6978, 57'h155_5555_5555_5555, 1, 1, 59 + NR, 1, 0, 0); // collision R5
    trial(32'h7777_8888, 64'h9999_AAAA_BBBB_CCCC, 57'h0AA_AAAA_AAAA_AAAA, 1, 0, 59 + NR, 0, 0, 0);
    trial(32'h0BAD_CAFE, 64'h0000_0000_0000_0001, 57'h123_4567_89AB_CDEF, 1, 0, 120, 1, 0, 0);   // late ref
    trial(32'h5555_AAAA, 64'h8000_0000_0000_0000, 57'h0F0_F0F0_F0F0_F0F0, 1, 0, 10, 0, 40, 1);   // R4 bad then good
    trial(32'hAAAA_5555, 64'hFFFF_FFFF_FFFF_FFFF, 57'h1FF_FFFF_FFFF_FFFF, 1, 1, 10, 1, 70, 0);   // R4 good then bad
    trial(32'h0000_0000, 64'h0000_0000_0000_0000, 57'h0, 0, 1, 60 + NR, 1, 61 + NR, 0);
    // constrained random
    for (int i = 0; i < 16; i++) begin
      logic [63:0] k = {$urandom, $urandom};
      logic [56:0] f = {25'($urandom), $urandom};
      int ea = 1 + int'($urandom % 130);
      int eb = ($urandom % 2 == 0) ? 0 : ea + 1 + int'($urandom % 60);
      trial($urandom, k, f, 1'($urandom), 1'($urandom), ea, 1'($urandom), eb, 1'($urandom));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule